// File: doc/BRIEF.md
# I/O-Port Watchdog Timer

This block is a watchdog timer that sits on a byte-wide I/O port bus. It answers at two addresses. The control/status port holds an enable bit, a stored mode bit, a 3-bit timeout selector and a sticky expiry flag. Any read of the trigger port restarts the countdown. A one-second tick comes from a prescaler that divides the system clock. The selector picks a timeout from a non-linear table: 2, 4, 6, 8, 16, 32, 48 or 64 seconds for index values 0 to 7.

On expiry the block always raises the sticky flag and clears the enable bit. It drives a fixed-length pulse on the system reset output only when the active-low safety-enable input is low; otherwise expiry is an alarm only. All of the block's registers, the flag included, are cleared only by the power-on reset. The pulse the block produces therefore never erases the record of why the system rebooted.

The controller has three states. From IDLE it goes to COUNT on a reload while enabled. COUNT goes back to IDLE when the enable bit is cleared, or on expiry when the safety enable is high. COUNT goes to PULSE on expiry when the safety enable is low. PULSE returns to IDLE after the reset pulse length. A reload while in COUNT stays in COUNT and restarts the timeout. Reloads that arrive during PULSE are ignored.

Top module: `wdt_portio`

## Requirements
- R1: A write to the control address (0x62) stores enable in bit 0, the mode in bit 1 and the timeout index in bits 5:3. A read of it returns these in the same positions, with the expiry flag in bit 7 and zeros in bits 2 and 6.
- R2: After power-on reset the control register reads 0x38: index 7 (64 s), enable 0, mode 0, flag 0. A read of the trigger address (0x66) returns 0x00.
- R3: With a clock of P cycles per second, a write that enables index i makes the expiry take effect at clock edge W+1+T(i)·P, where W is the write edge. T is the table 2,4,6,8,16,32,48,64.
- R4: A read of the trigger address while enabled restarts the full timeout, counted from that read's edge (K+1+T·P). While disabled such a read has no effect.
- R5: A control write reloads the countdown when it sets enable from 0 to 1 or changes the index while enabling. Rewriting identical values does not restart the count.
- R6: Clearing the enable bit stops the countdown: no expiry, no flag and no reset follow.
- R7: Expiry sets the flag (bit 7) and clears the enable bit (bit 0).
- R8: On expiry with the safety enable low, the reset output is high for exactly RST_CYCLES clock cycles, starting in the cycle after the expiry edge.
- R9: On expiry with the safety enable high, the reset output stays low and only the flag is set.
- R10: Writing 1 to bit 7 clears the flag. Writing 0 to bit 7 leaves it unchanged.
- R11: The flag keeps its value through the reset pulse the block produces. Only the power-on reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Active-low power-on reset, clears all registers |
| io_addr | input | 8 | I/O port address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational from the address |
| safe_en_n | input | 1 | Active-low permission to drive the reset output |
| sys_rst | output | 1 | System reset pulse on expiry |

## Verification
The bench builds the block with CLK_PER_SEC = 4 and RST_CYCLES = 5. One simulated second is then four clocks, and even the 64-second entry expires in 256 cycles. This makes it affordable to sweep all eight table entries and check each expiry at its exact edge. The short pulse lets every sweep step measure the whole reset pulse. It also makes the timing comparisons sharp: checks that a kick or an index change restarted the count, or that an identical rewrite did not, land only a few cycles apart.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int SEC_W = 7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COUNT,
        ST_PULSE
    } wd_state_e;

    // Non-linear timeout table, seconds per 3-bit index
    function automatic logic [SEC_W-1:0] secs_of(input logic [2:0] sel);
        logic [SEC_W-1:0] s;
        case (sel)
            3'd0: s = 7'd2;
            3'd1: s = 7'd4;
            3'd2: s = 7'd6;
            3'd3: s = 7'd8;
            3'd4: s = 7'd16;
            3'd5: s = 7'd32;
            3'd6: s = 7'd48;
            default: s = 7'd64;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs #(
    parameter logic [7:0] ADDR_CTRL = 8'h62,
    parameter logic [7:0] ADDR_KICK = 8'h66
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic [7:0] io_addr,
    input  logic       io_wr,
    input  logic       io_rd,
    input  logic [7:0] io_wdata,
    output logic [7:0] io_rdata,
    input  logic       expire,
    output logic       en,
    output logic       mode,
    output logic [2:0] idx,
    output logic       flag,
    output logic       reload
);

    logic wr_ctrl;
    logic kick;

    assign wr_ctrl = io_wr && (io_addr == ADDR_CTRL);
    assign kick    = io_rd && (io_addr == ADDR_KICK);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            en     <= 1'b0;
            mode   <= 1'b0;
            idx    <= 3'd7;
            flag   <= 1'b0;
            reload <= 1'b0;
        end else begin
            reload <= 1'b0;
            if (wr_ctrl) begin
                en     <= io_wdata[0];
                mode   <= io_wdata[1];
                idx    <= io_wdata[5:3];
                reload <= io_wdata[0] && (!en || (io_wdata[5:3] != idx));
                if (io_wdata[7]) begin
                    flag <= 1'b0;
                end
            end
            if (kick && en) begin
                reload <= 1'b1;
            end
            if (expire) begin
                en     <= 1'b0;
                flag   <= 1'b1;
                reload <= 1'b0;
            end
        end
    end

    always_comb begin
        io_rdata = 8'h00;
        if (io_addr == ADDR_CTRL) begin
            io_rdata = {flag, 1'b0, idx, 1'b0, mode, en};
        end
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!por_n)
        expire |=> flag); // R7
    AST_EN_DROP: assert property (@(posedge clk) disable iff (!por_n)
        expire |=> !en); // R7
    AST_W1C: assert property (@(posedge clk) disable iff (!por_n)
        (wr_ctrl && io_wdata[7] && !expire) |=> !flag); // R10
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        (!expire && !(wr_ctrl && io_wdata[7])) |=> (flag == $past(flag))); // R11

endmodule

// File: rtl/wdt_tick.sv
module wdt_tick #(
    parameter int DIV = 50_000_000
) (
    input  logic clk,
    input  logic por_n,
    input  logic run,
    input  logic clr,
    output logic tick
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt <= '0;
        end else if (!run || clr || (cnt == LAST)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && !clr && (cnt == LAST);

    AST_TICK_IDLE: assert property (@(posedge clk) disable iff (!por_n)
        !run |=> (cnt == '0)); // R3

endmodule

// File: rtl/wdt_ctl.sv
module wdt_ctl
    import wdt_pkg::*;
#(
    parameter int RST_CYCLES = 32
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       en,
    input  logic [2:0] idx,
    input  logic       reload,
    input  logic       safe_en_n,
    input  logic       tick,
    output logic       run,
    output logic       expire,
    output logic       rst_out
);

    localparam int PW = $clog2(RST_CYCLES + 1);
    localparam logic [PW-1:0] P_LAST = PW'(RST_CYCLES - 1);

    wd_state_e        state, nxt;
    logic [SEC_W-1:0] secs;
    logic [PW-1:0]    pcnt;

    assign expire = (state == ST_COUNT) && en && !reload && tick && (secs == 7'd1);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (reload && en) nxt = ST_COUNT;
            end
            ST_COUNT: begin
                if (!en)          nxt = ST_IDLE;
                else if (expire)  nxt = safe_en_n ? ST_IDLE : ST_PULSE;
            end
            ST_PULSE: begin
                if (pcnt == P_LAST) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            secs <= '0;
            pcnt <= '0;
        end else begin
            if (reload && state != ST_PULSE) begin
                secs <= secs_of(idx);
            end else if (tick && state == ST_COUNT) begin
                secs <= secs - 1'b1;
            end
            pcnt <= (state == ST_PULSE) ? pcnt + 1'b1 : '0;
        end
    end

    always_comb begin
        run     = (state == ST_COUNT);
        rst_out = (state == ST_PULSE);
    end

    AST_RST_GATED: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_out) |-> $past(!safe_en_n)); // R8
    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_out) |-> ($past(pcnt) == P_LAST)); // R8
    AST_ALARM_ONLY: assert property (@(posedge clk) disable iff (!por_n)
        (expire && safe_en_n) |=> !rst_out); // R9
    AST_STOP: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_COUNT && !en) |=> (state == ST_IDLE)); // R6
    AST_SECS_RANGE: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_COUNT) |-> (secs != '0 && secs <= 7'd64)); // R3

endmodule

// File: rtl/wdt_portio.sv
module wdt_portio #(
    parameter int         CLK_PER_SEC = 50_000_000,
    parameter int         RST_CYCLES  = 32,
    parameter logic [7:0] ADDR_CTRL   = 8'h62,
    parameter logic [7:0] ADDR_KICK   = 8'h66
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic [7:0] io_addr,
    input  logic       io_wr,
    input  logic       io_rd,
    input  logic [7:0] io_wdata,
    output logic [7:0] io_rdata,
    input  logic       safe_en_n,
    output logic       sys_rst
);

    logic       en, mode, flag, reload;
    logic [2:0] idx;
    logic       run, tick, expire;

    wdt_regs #(
        .ADDR_CTRL (ADDR_CTRL),
        .ADDR_KICK (ADDR_KICK)
    ) u_regs (
        .clk      (clk),
        .por_n    (por_n),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .expire   (expire),
        .en       (en),
        .mode     (mode),
        .idx      (idx),
        .flag     (flag),
        .reload   (reload)
    );

    wdt_tick #(
        .DIV (CLK_PER_SEC)
    ) u_tick (
        .clk   (clk),
        .por_n (por_n),
        .run   (run),
        .clr   (reload),
        .tick  (tick)
    );

    wdt_ctl #(
        .RST_CYCLES (RST_CYCLES)
    ) u_ctl (
        .clk       (clk),
        .por_n     (por_n),
        .en        (en),
        .idx       (idx),
        .reload    (reload),
        .safe_en_n (safe_en_n),
        .tick      (tick),
        .run       (run),
        .expire    (expire),
        .rst_out   (sys_rst)
    );

endmodule

// File: tb/wdt_portio_bench.sv
module wdt_portio_bench;

    localparam int P    = 4;
    localparam int RSTC = 5;
    localparam logic [7:0] A_CTRL = 8'h62;
    localparam logic [7:0] A_KICK = 8'h66;

    logic       clk = 1'b0;
    logic       por_n;
    logic [7:0] io_addr;
    logic       io_wr, io_rd;
    logic [7:0] io_wdata;
    logic [7:0] io_rdata;
    logic       safe_en_n;
    logic       sys_rst;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];
    event  smp;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdt_portio #(
        .CLK_PER_SEC (P),
        .RST_CYCLES  (RSTC)
    ) u_wdt_portio (
        .clk       (clk),
        .por_n     (por_n),
        .io_addr   (io_addr),
        .io_wr     (io_wr),
        .io_rd     (io_rd),
        .io_wdata  (io_wdata),
        .io_rdata  (io_rdata),
        .safe_en_n (safe_en_n),
        .sys_rst   (sys_rst)
    );

    function automatic int tsec(input int i);
        case (i)
            0: return 2;  1: return 4;  2: return 6;  3: return 8;
            4: return 16; 5: return 32; 6: return 48; default: return 64;
        endcase
    endfunction

    task automatic check_eq(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data and compares
    initial begin
        forever begin
            @(smp);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check_eq(it.tag, io_rdata, it.exp);
            end
        end
    end

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        io_addr = a;
        io_rd   = 1'b1;
        sb.push_back('{exp: exp, tag: tag});
        #5 -> smp;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr  = a;
        io_wdata = d;
        io_wr    = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic chk_rst(input logic e, input string tag);
        check_eq(tag, {7'b0, sys_rst}, {7'b0, e});
    endtask

    // expiry relative to the access edge e0 with tp clocks of timeout
    task automatic expect_window(input int e0, input int tp, input bit pulse, input string tag);
        wait_until(e0 + tp);
        chk_rst(1'b0, {tag, " before expiry"});
        wait_until(e0 + tp + 1);
        chk_rst(pulse, {tag, " at expiry"});
        wait_until(e0 + tp + RSTC);
        chk_rst(pulse, {tag, " pulse end"});
        wait_until(e0 + tp + RSTC + 1);
        chk_rst(1'b0, {tag, " after pulse"});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int e0, e1;
        por_n = 1'b0; io_addr = 8'h00; io_wr = 1'b0; io_rd = 1'b0;
        io_wdata = 8'h00; safe_en_n = 1'b0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;

        // R2 reset state, R4 kick ignored while disabled
        rd(A_CTRL, 8'h38, "R2 ctrl reset");
        rd(A_KICK, 8'h00, "R2 kick data");
        e0 = cyc;
        wait_until(e0 + 20);
        chk_rst(1'b0, "R4 kick while disabled");
        rd(A_CTRL, 8'h38, "R4 no effect when disabled");

        // R1 layout and mode readback
        wr(A_CTRL, 8'h2A);
        rd(A_CTRL, 8'h2A, "R1 readback");

        // R3 table sweep, R8 pulse, R7/R11 flag after pulse
        for (int i = 0; i < 8; i++) begin
            wr(A_CTRL, {2'b00, 3'(i), 3'b001});
            e0 = cyc;
            expect_window(e0, tsec(i) * P, 1'b1, "R3 R8 table");
            rd(A_CTRL, {1'b1, 1'b0, 3'(i), 3'b000}, "R7 R11 flag after pulse");
            wr(A_CTRL, 8'h80);
        end

        // R4 kick restarts
        wr(A_CTRL, 8'h01);
        e0 = cyc;
        wait_until(e0 + 5);
        rd(A_KICK, 8'h00, "R4 kick data");
        e1 = cyc;
        wait_until(e0 + 10);
        chk_rst(1'b0, "R4 old expiry suppressed");
        expect_window(e1, 2 * P, 1'b1, "R4 kick");
        wr(A_CTRL, 8'h80);

        // R5 identical rewrite does not restart
        wr(A_CTRL, 8'h09);
        e0 = cyc;
        wait_until(e0 + 6);
        wr(A_CTRL, 8'h09);
        expect_window(e0, 4 * P, 1'b1, "R5 same rewrite");
        wr(A_CTRL, 8'h80);

        // R5 index change reloads
        wr(A_CTRL, 8'h01);
        e0 = cyc;
        wait_until(e0 + 4);
        wr(A_CTRL, 8'h09);
        e1 = cyc;
        wait_until(e0 + 10);
        chk_rst(1'b0, "R5 old timeout replaced");
        expect_window(e1, 4 * P, 1'b1, "R5 index change");
        wr(A_CTRL, 8'h80);

        // R6 disable stops
        wr(A_CTRL, 8'h01);
        e0 = cyc;
        wait_until(e0 + 3);
        wr(A_CTRL, 8'h00);
        wait_until(e0 + 30);
        chk_rst(1'b0, "R6 stopped");
        rd(A_CTRL, 8'h00, "R6 no flag");

        // R9 alarm only
        safe_en_n = 1'b1;
        wr(A_CTRL, 8'h01);
        e0 = cyc;
        expect_window(e0, 2 * P, 1'b0, "R9 alarm only");
        rd(A_CTRL, 8'h80, "R9 R7 flag set en cleared");

        // R10 write-one-to-clear
        wr(A_CTRL, 8'h00);
        rd(A_CTRL, 8'h80, "R10 write 0 keeps flag");
        wr(A_CTRL, 8'h80);
        rd(A_CTRL, 8'h00, "R10 write 1 clears flag");

        // R11 flag survives own pulse, cleared by power-on only
        safe_en_n = 1'b0;
        wr(A_CTRL, 8'h01);
        e0 = cyc;
        expect_window(e0, 2 * P, 1'b1, "R11 pulse");
        rd(A_CTRL, 8'h80, "R11 flag after pulse");
        @(negedge clk);
        por_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        rd(A_CTRL, 8'h38, "R11 power-on clears flag");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule